// File: doc/BRIEF.md
# CAN Bit Timing and Resynchronization Unit

This block turns a system clock into the time-quantum grid of a CAN node and lays each bit on that grid. A bit has three parts: a one-quantum synchronization part, a first phase part and a second phase part. The lengths of both phase parts are programmable. The receive line is read at the end of the first phase part. A transmit-point strobe marks the start of every bit's synchronization quantum. Falling edges on the receive line keep the local bit grid aligned to the bus. While the bus is idle, any such edge restarts the bit outright. Otherwise the unit shifts the grid by the measured phase error, limited to a programmable jump width.

The programming inputs are raw register fields, and each one is offset-encoded. The divider is the prescaler field plus two. The first phase length is its field plus one. The second phase length is its field plus one. The jump width is its field plus one, capped at the second phase length. Frame decoding, stuffing and arbitration sit in the neighbouring logic, which uses the strobes and the sampled bit.

Top module: `can_bit_timer`

## Requirements
- R1: `tq_stb_o` is high for exactly one clock out of every `psc_raw_i + 2` clocks.
- R2: With no falling edge on `rx_i`, `tx_stb_o` repeats every `3 + tseg1_raw_i + tseg2_raw_i` quanta. `sample_stb_o` comes `tseg1_raw_i + 2` quanta after each `tx_stb_o`, on the strobe that ends the last quantum of the first phase part.
- R3: `rx_bit_o` takes the value `rx_i` had at the quantum edge where a sample occurs, and holds it otherwise.
- R4: `sample_stb_o` and `tx_stb_o` only rise together with `tq_stb_o`, and never both in the same clock.
- R5: An edge is recognised only at a quantum edge, and only when `rx_i` was 1 at the previous quantum edge and is 0 now (1 = recessive, 0 = dominant). A rising transition never moves the bit grid.
- R6: An edge seen at the end of the k-th quantum of the first phase part (k counted from 1) is a late error e = k. The first phase part of that bit grows by min(e, SJW) quanta.
- R7: An edge seen in the second phase part, with r quanta of it not yet started, is an early error e = -r. The second phase part shrinks by min(r, SJW), and a bit whose second phase part shrinks to nothing goes straight on to its synchronization quantum. When r = 0, or the edge falls in the synchronization quantum, nothing changes.
- R8: SJW = min(`sjw_raw_i` + 1, `tseg2_raw_i` + 1).
- R9: At most one resynchronization happens between two sample points. A hard synchronization also blocks any further resynchronization until the next sample point.
- R10: While `bus_idle_i` is 1, an edge makes the quantum in which it was seen the synchronization quantum. The next quantum is the first of the first phase part, pending adjustments are dropped, and no sample or transmit strobe is given on that quantum edge.
- R11: While `rst_n` is low, all strobes are 0 and `rx_bit_o` is 1. After release the bit grid starts at the synchronization quantum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Receive line, 0 = dominant, synchronous to clk |
| psc_raw_i | input | 6 | Prescaler field, divide by value + 2 |
| tseg1_raw_i | input | 4 | First phase length field, value + 1 quanta |
| tseg2_raw_i | input | 3 | Second phase length field, value + 1 quanta |
| sjw_raw_i | input | 2 | Jump width field, value + 1 quanta |
| bus_idle_i | input | 1 | Bus idle: edges cause hard synchronization |
| tq_stb_o | output | 1 | One-clock pulse per time quantum |
| sample_stb_o | output | 1 | One-clock pulse at the sample point |
| rx_bit_o | output | 1 | Bit captured at the last sample point |
| tx_stb_o | output | 1 | One-clock pulse at the start of each bit |

## Verification
All four outputs are registered. Each one reacts in the clock right after the rising edge at which the prescaler reaches its last count, and `rx_i` is evaluated on that same edge. An input change therefore shows up in the outputs only at the end of the quantum in which it happened, one clock after that quantum's final edge. The bench's reference model steps on each rising edge from the same inputs. The bench then compares every output on the falling edge that follows, so each result is checked in the cycle it is due. Inputs change only on falling edges, after the comparison.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_PH1  = 2'd1,
    SEG_PH2  = 2'd2
  } seg_e;
endpackage

// File: rtl/can_bt_prescaler.sv
module can_bt_prescaler #(
  parameter int PSC_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PSC_W-1:0] psc_raw_i,
  output logic             tick_o
);
  localparam int DIV_W = PSC_W + 1;

  logic [DIV_W-1:0] cnt_q, cnt_d, last_c;

  // Divider is field + 2, so the terminal count is field + 1.
  always_comb begin
    last_c = {1'b0, psc_raw_i} + DIV_W'(1);
    tick_o = (cnt_q == last_c);
    cnt_d  = tick_o ? '0 : cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/can_bt_edge.sv
module can_bt_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic rx_i,
  output logic fall_o
);
  logic rx_last_q, rx_last_d;

  // The line is looked at once per quantum; a fall is recessive then dominant.
  always_comb begin
    rx_last_d = tick_i ? rx_i : rx_last_q;
    fall_o    = tick_i & rx_last_q & ~rx_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_last_q <= 1'b1;
    else        rx_last_q <= rx_last_d;
  end
endmodule

// File: rtl/can_bt_resync.sv
module can_bt_resync
  import can_bt_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int SJ_W  = 3
) (
  input  seg_e             seg_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] len2_i,
  input  logic [SJ_W-1:0]  sjw_i,
  input  logic [SJ_W-1:0]  ext_i,
  input  logic [SJ_W-1:0]  cut_i,
  input  logic             fall_i,
  input  logic             idle_i,
  input  logic             done_i,
  output logic [SJ_W-1:0]  ext_o,
  output logic [SJ_W-1:0]  cut_o,
  output logic             resync_o
);
  logic [CNT_W-1:0] rem_c, mag_c, sjw_x, step_w;
  logic [SJ_W-1:0]  step_c;
  logic             late_c, early_c;

  always_comb begin
    // Quanta of the second phase still to come after the current one.
    rem_c   = len2_i - cnt_i - CNT_W'(1);
    late_c  = (seg_i == SEG_PH1);
    early_c = (seg_i == SEG_PH2) && (rem_c != '0);
    mag_c   = late_c ? cnt_i + CNT_W'(1) : rem_c;
    sjw_x   = CNT_W'(sjw_i);
    step_w  = (mag_c > sjw_x) ? sjw_x : mag_c;
    step_c  = SJ_W'(step_w);

    resync_o = fall_i & ~idle_i & ~done_i & (late_c | early_c);
    ext_o    = (resync_o && late_c)  ? ext_i + step_c : ext_i;
    cut_o    = (resync_o && early_c) ? step_c         : cut_i;
  end
endmodule

// File: rtl/can_bt_segfsm.sv
module can_bt_segfsm
  import can_bt_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int SJ_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             hard_i,
  input  logic             resync_i,
  input  logic [SJ_W-1:0]  ext_n_i,
  input  logic [SJ_W-1:0]  cut_n_i,
  input  logic [CNT_W-1:0] len1_i,
  input  logic [CNT_W-1:0] len2_i,
  output seg_e             seg_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [SJ_W-1:0]  ext_o,
  output logic [SJ_W-1:0]  cut_o,
  output logic             done_o,
  output logic             smp_o,
  output logic             tx_o
);
  seg_e             seg_q, seg_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, len1e_c;
  logic [SJ_W-1:0]  ext_q, ext_d, cut_q, cut_d;
  logic             done_q, done_d, last1_c, last2_c;

  always_comb begin
    seg_d   = seg_q;
    cnt_d   = cnt_q;
    ext_d   = ext_q;
    cut_d   = cut_q;
    done_d  = done_q;
    smp_o   = 1'b0;
    tx_o    = 1'b0;
    len1e_c = len1_i + CNT_W'(ext_n_i);
    last1_c = (cnt_q == len1e_c - CNT_W'(1));
    last2_c = ((cnt_q + CNT_W'(cut_n_i)) == len2_i - CNT_W'(1));
    if (tick_i) begin
      ext_d  = ext_n_i;
      cut_d  = cut_n_i;
      done_d = done_q | resync_i;
      if (hard_i) begin
        seg_d  = SEG_PH1;
        cnt_d  = '0;
        ext_d  = '0;
        cut_d  = '0;
        done_d = 1'b1;
      end else begin
        unique case (seg_q)
          SEG_SYNC: begin
            seg_d = SEG_PH1;
            cnt_d = '0;
          end
          SEG_PH1: begin
            if (last1_c) begin
              seg_d  = SEG_PH2;
              cnt_d  = '0;
              smp_o  = 1'b1;
              done_d = 1'b0;
            end else begin
              cnt_d = cnt_q + CNT_W'(1);
            end
          end
          SEG_PH2: begin
            if (last2_c) begin
              seg_d = SEG_SYNC;
              cnt_d = '0;
              ext_d = '0;
              cut_d = '0;
              tx_o  = 1'b1;
            end else begin
              cnt_d = cnt_q + CNT_W'(1);
            end
          end
          default: begin
            seg_d = SEG_SYNC;
            cnt_d = '0;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q  <= SEG_SYNC;
      cnt_q  <= '0;
      ext_q  <= '0;
      cut_q  <= '0;
      done_q <= 1'b0;
    end else begin
      seg_q  <= seg_d;
      cnt_q  <= cnt_d;
      ext_q  <= ext_d;
      cut_q  <= cut_d;
      done_q <= done_d;
    end
  end

  assign seg_o  = seg_q;
  assign cnt_o  = cnt_q;
  assign ext_o  = ext_q;
  assign cut_o  = cut_q;
  assign done_o = done_q;
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
  import can_bt_pkg::*;
#(
  parameter int PSC_W = 6,
  parameter int TS1_W = 4,
  parameter int TS2_W = 3,
  parameter int SJW_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_i,
  input  logic [PSC_W-1:0] psc_raw_i,
  input  logic [TS1_W-1:0] tseg1_raw_i,
  input  logic [TS2_W-1:0] tseg2_raw_i,
  input  logic [SJW_W-1:0] sjw_raw_i,
  input  logic             bus_idle_i,
  output logic             tq_stb_o,
  output logic             sample_stb_o,
  output logic             rx_bit_o,
  output logic             tx_stb_o
);
  localparam int CNT_W = $clog2((1 << TS1_W) + (1 << SJW_W) + 1);
  localparam int SJ_W  = SJW_W + 1;

  logic             tick, fall, hard, resync, done, smp_evt, tx_evt;
  logic [CNT_W-1:0] len1, len2, sjw_want, cnt;
  logic [SJ_W-1:0]  sjw_eff, ext_q, cut_q, ext_n, cut_n;
  seg_e             seg;

  logic tq_q, tq_d, smp_q, smp_d, tx_q, tx_d, bit_q, bit_d;

  // Offset-encoded fields; jump width limited by the second phase length.
  always_comb begin
    len1     = CNT_W'(tseg1_raw_i) + CNT_W'(1);
    len2     = CNT_W'(tseg2_raw_i) + CNT_W'(1);
    sjw_want = CNT_W'(sjw_raw_i) + CNT_W'(1);
    sjw_eff  = SJ_W'((sjw_want > len2) ? len2 : sjw_want);
    hard     = fall & bus_idle_i;
  end

  can_bt_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .psc_raw_i(psc_raw_i), .tick_o(tick)
  );

  can_bt_edge u_edge (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .rx_i(rx_i), .fall_o(fall)
  );

  can_bt_resync #(.CNT_W(CNT_W), .SJ_W(SJ_W)) u_rsy (
    .seg_i(seg), .cnt_i(cnt), .len2_i(len2), .sjw_i(sjw_eff),
    .ext_i(ext_q), .cut_i(cut_q), .fall_i(fall), .idle_i(bus_idle_i),
    .done_i(done), .ext_o(ext_n), .cut_o(cut_n), .resync_o(resync)
  );

  can_bt_segfsm #(.CNT_W(CNT_W), .SJ_W(SJ_W)) u_seg (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .hard_i(hard),
    .resync_i(resync), .ext_n_i(ext_n), .cut_n_i(cut_n),
    .len1_i(len1), .len2_i(len2), .seg_o(seg), .cnt_o(cnt),
    .ext_o(ext_q), .cut_o(cut_q), .done_o(done),
    .smp_o(smp_evt), .tx_o(tx_evt)
  );

  always_comb begin
    tq_d  = tick;
    smp_d = smp_evt;
    tx_d  = tx_evt;
    bit_d = smp_evt ? rx_i : bit_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tq_q  <= 1'b0;
      smp_q <= 1'b0;
      tx_q  <= 1'b0;
      bit_q <= 1'b1;
    end else begin
      tq_q  <= tq_d;
      smp_q <= smp_d;
      tx_q  <= tx_d;
      bit_q <= bit_d;
    end
  end

  assign tq_stb_o     = tq_q;
  assign sample_stb_o = smp_q;
  assign tx_stb_o     = tx_q;
  assign rx_bit_o     = bit_q;
endmodule

// File: rtl/can_bit_timer_chk.sv
module can_bit_timer_chk #(
  parameter int SJ_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tq,
  input logic            smp,
  input logic            tx,
  input logic            rx_bit,
  input logic [SJ_W-1:0] ext,
  input logic [SJ_W-1:0] cut,
  input logic [SJ_W-1:0] sjw
);
  AST_TQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) tq |=> !tq); // R1
  AST_SAMPLE_ON_TQ: assert property (@(posedge clk) disable iff (!rst_n) smp |-> tq); // R4
  AST_TX_ON_TQ: assert property (@(posedge clk) disable iff (!rst_n) tx |-> tq); // R4
  AST_SAMPLE_TX_APART: assert property (@(posedge clk) disable iff (!rst_n) !(smp && tx)); // R4
  AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !smp |-> $stable(rx_bit)); // R3
  AST_EXT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) ext <= sjw); // R6
  AST_CUT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) cut <= sjw); // R7
endmodule

bind can_bit_timer can_bit_timer_chk #(.SJ_W(SJ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tq(tq_stb_o), .smp(sample_stb_o),
  .tx(tx_stb_o), .rx_bit(rx_bit_o), .ext(ext_q), .cut(cut_q), .sjw(sjw_eff)
);

// File: tb/can_bit_timer_test.sv
module can_bit_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic       idle = 1'b0;
  logic [5:0] psc_raw = '0;
  logic [3:0] ts1_raw = '0;
  logic [2:0] ts2_raw = '0;
  logic [1:0] sjw_raw = '0;
  logic       tq, smp, rxb, tx;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  can_bit_timer uut (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .psc_raw_i(psc_raw),
    .tseg1_raw_i(ts1_raw), .tseg2_raw_i(ts2_raw), .sjw_raw_i(sjw_raw),
    .bus_idle_i(idle), .tq_stb_o(tq), .sample_stb_o(smp),
    .rx_bit_o(rxb), .tx_stb_o(tx)
  );

  // Reference model: position p within the bit (0 = sync quantum).
  int m_pc, m_p, m_ext, m_cut;
  bit m_done, m_rxl, m_tq, m_smp, m_tx, m_rxbit;

  always @(posedge clk) begin : model
    int psc, l1, l2, sjw, l1e, endp, k, rem, s;
    bit tick, fall;
    if (!rst_n) begin
      m_pc = 0; m_p = 0; m_ext = 0; m_cut = 0; m_done = 0; m_rxl = 1;
      m_tq = 0; m_smp = 0; m_tx = 0; m_rxbit = 1;
    end else begin
      psc = psc_raw + 2;
      l1  = ts1_raw + 1;
      l2  = ts2_raw + 1;
      sjw = (sjw_raw + 1 < l2) ? sjw_raw + 1 : l2;
      tick = (m_pc == psc - 1);
      m_pc = tick ? 0 : m_pc + 1;
      m_tq = tick; m_smp = 0; m_tx = 0;
      if (tick) begin
        fall = m_rxl && !rx;
        if (fall && idle) begin
          m_p = 1; m_ext = 0; m_cut = 0; m_done = 1;
        end else begin
          if (fall && !m_done && m_p != 0) begin
            if (m_p <= l1 + m_ext) begin
              s = (m_p < sjw) ? m_p : sjw;
              m_ext += s; m_done = 1;
            end else begin
              k = m_p - (l1 + m_ext) - 1;
              rem = l2 - 1 - k;
              if (rem > 0) begin
                s = (rem < sjw) ? rem : sjw;
                m_cut = s; m_done = 1;
              end
            end
          end
          l1e  = l1 + m_ext;
          endp = l1e + l2 - m_cut;
          if (m_p == l1e) begin m_smp = 1; m_rxbit = rx; m_done = 0; end
          if (m_p == endp) begin m_p = 0; m_ext = 0; m_cut = 0; m_tx = 1; end
          else m_p++;
        end
        m_rxl = rx;
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    chk("R1", "tq strobe", tq, m_tq);
    chk(tag, "sample strobe", smp, m_smp);
    chk(tag, "tx strobe", tx, m_tx);
    chk("R3", "sampled bit", rxb, m_rxbit);
    chk("R4", "strobe outside tq", (smp | tx) & ~tq, 0);
  endtask

  // mode 0: line recessive; 1: remote sender; 2: noise; 3: remote sender with bus idle
  task automatic run_scn(input string tag, input int p, input int t1, input int t2,
                         input int sj, input int mode, input int ncyc, input int rper);
    int rcnt = 0;
    @(negedge clk);
    rst_n = 1'b0;
    psc_raw = p[5:0]; ts1_raw = t1[3:0]; ts2_raw = t2[2:0]; sjw_raw = sj[1:0];
    rx = 1'b1; idle = (mode == 3);
    repeat (3) @(negedge clk);
    chk("R11", "reset tq", tq, 0);
    chk("R11", "reset sample", smp, 0);
    chk("R11", "reset tx", tx, 0);
    chk("R11", "reset bit", rxb, 1);
    rst_n = 1'b1;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      compare(tag);
      if (mode == 1 || mode == 3) begin
        if (rcnt == 0) begin
          rx = 1'($urandom_range(0, 1));
          rcnt = rper - 1;
        end else rcnt--;
      end else if (mode == 2) begin
        if ($urandom_range(0, 5) == 0) rx = ~rx;
      end
    end
  endtask

  initial begin
    run_scn("R2", 0, 3, 2, 1, 0, 400, 1);
    run_scn("R5", 1, 5, 3, 1, 1, 3000, 33);
    run_scn("R6", 0, 7, 3, 1, 1, 4000, 29);
    run_scn("R7", 0, 7, 3, 1, 1, 4000, 23);
    run_scn("R8", 2, 4, 0, 3, 1, 4000, 25);
    run_scn("R9", 0, 6, 4, 3, 2, 3000, 1);
    run_scn("R10", 1, 3, 2, 0, 3, 3000, 40);
    run_scn("R6", 13, 15, 7, 3, 1, 20000, 420);
    run_scn("R7", 13, 15, 7, 3, 1, 20000, 330);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule